// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits in front of one processor core and decides which interrupt, if any, is presented to it. It keeps exactly one pending slot, shared between external interrupts offered by a source controller and a built-in inter-processor request. Each candidate is judged against the core's current priority. A smaller number is more favoured, and 0xFF is the least favoured value, meaning "none". A candidate that loses, or that is pushed out of the slot by a better one, is handed back to its source through a reject pulse. The source controller then keeps it and offers it again when asked to resend.

The core talks to the block through a small operation port. It can take the pending interrupt (accept), look at it without side effects (poll), set its current priority, signal end of interrupt, and set the priority of the inter-processor request. The pending word is always visible. Bits 31:24 hold the current priority and bits 23:0 hold the pending source number, where zero means nothing is pending. A single level output tells the core that an interrupt is presented.

Top module: `ipc_core`

## Requirements
- R1: After reset the pending word reads 0, the request priority reads 0xFF, the interrupt output is low and no reject, end-of-interrupt or resend pulse is given.
- R2: `rd_word` carries the current priority in bits 31:24 and the pending source in bits 23:0, and `irq_out` is high exactly when that source field is non-zero.
- R3: An offer is refused in the same cycle (`ofr_reject` high) when its priority is not strictly smaller than the current priority, or when a pending interrupt has an equal or smaller priority, or when its source number is 0. A refused offer leaves the pending word unchanged.
- R4: A winning offer latches its source and priority and raises `irq_out` on the next cycle. If it displaces an external interrupt, `rej_valid` pulses the cycle after the offer, with `rej_src` giving the displaced source.
- R5: Operation code 5 stores `op_wdata[7:0]` as the request priority. If that value is below the current priority and no pending interrupt has an equal or smaller priority, any pending external interrupt is rejected and source 2 is loaded with the request priority.
- R6: Operation code 1 (accept) returns the pending word on `rd_word` in its own cycle. On the next cycle the current priority equals the accepted pending priority, the source field is 0 and `irq_out` is low. Accepting an empty slot sets the current priority to 0xFF.
- R7: Operation code 2 (poll) changes no state, and `rd_req_pri` always shows the request priority.
- R8: Operation code 3 sets the current priority to `op_wdata[7:0]`. When the new value is smaller and is less than or equal to the pending priority, the pending interrupt is removed and `irq_out` drops. An external interrupt removed this way is rejected; a removed inter-processor request is not.
- R9: When operation code 3 writes a value greater than or equal to the old priority while nothing is pending, `resend_req` pulses. The inter-processor request is then loaded if its priority is below the new current priority.
- R10: Operation code 4 (end of interrupt) copies `op_wdata[31:24]` into the current priority and pulses `eoi_valid`, with `eoi_src` equal to `op_wdata[23:0]`. If nothing is pending it also pulses `resend_req` and runs the inter-processor check against the new priority.
- R11: When an operation and an offer arrive in the same cycle, the operation takes effect first and the offer is judged against the resulting state.
- R12: Reject, end-of-interrupt and resend outputs are one-cycle pulses that appear in the cycle after their cause. Operation code 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Operation: 0 idle, 1 accept, 2 poll, 3 set priority, 4 end of interrupt, 5 set request priority |
| op_wdata | input | 32 | Write data for operations 3, 4 and 5 |
| rd_word | output | 32 | Pending word: current priority and pending source |
| rd_req_pri | output | 8 | Inter-processor request priority |
| ofr_valid | input | 1 | Source controller offers an interrupt |
| ofr_src | input | 24 | Offered source number |
| ofr_pri | input | 8 | Offered priority |
| ofr_reject | output | 1 | Same-cycle refusal of the offer |
| irq_out | output | 1 | Interrupt line to the core |
| rej_valid | output | 1 | Pulse: an interrupt is handed back to the source controller |
| rej_src | output | 24 | Source number handed back |
| eoi_valid | output | 1 | Pulse: end of interrupt forwarded to the source controller |
| eoi_src | output | 24 | Source number of the end of interrupt |
| resend_req | output | 1 | Pulse: source controller should offer its interrupts again |

## Verification
The offer refusal is combinational, so the bench judges it a moment after driving the offer and before the clock edge. The pending word, the request priority, the interrupt line and the three pulse outputs all change at the first rising edge after the stimulus. The bench therefore drives on a falling edge, steps its own model, and compares those outputs at the following falling edge. An accept read is compared in its own cycle, before the edge that clears the slot. Directed cases put operations and offers on the same cycle and hit priority ties. Random traffic draws priorities from a narrow range so that equal values happen often.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    localparam int PRI_W   = 8;
    localparam int SRC_W   = 24;
    localparam int WORD_W  = PRI_W + SRC_W;
    localparam int OP_W    = 3;
    localparam logic [PRI_W-1:0] PRI_NONE = '1;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE    = 3'd0,
        OP_ACCEPT  = 3'd1,
        OP_POLL    = 3'd2,
        OP_SET_PRI = 3'd3,
        OP_EOI     = 3'd4,
        OP_SET_REQ = 3'd5
    } ipc_op_e;

    // Architectural state of the presenter
    typedef struct packed {
        logic [PRI_W-1:0] cur_pri;   // processor priority
        logic [SRC_W-1:0] src;       // pending source, 0 = empty
        logic [PRI_W-1:0] pend_pri;  // priority of pending source
        logic             owned;     // pending source belongs to the source controller
        logic [PRI_W-1:0] req_pri;   // inter-processor request priority
    } ipc_state_t;

    // A pulse carrying a source number
    typedef struct packed {
        logic             valid;
        logic [SRC_W-1:0] src;
    } ipc_note_t;

    typedef struct packed {
        ipc_state_t st;
        ipc_note_t  rej;
    } ipc_step_t;

    function automatic logic slot_busy(input ipc_state_t s);
        return s.src != '0;
    endfunction

    // Try to place the inter-processor request into the slot
    function automatic ipc_step_t req_try(input ipc_state_t s,
                                          input logic [SRC_W-1:0] req_num);
        ipc_step_t r;
        r.st  = s;
        r.rej = '0;
        if (!(slot_busy(s) && s.pend_pri <= s.req_pri)) begin
            if (slot_busy(s) && s.owned) begin
                r.rej.valid = 1'b1;
                r.rej.src   = s.src;
            end
            r.st.src      = req_num;
            r.st.pend_pri = s.req_pri;
            r.st.owned    = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/ipc_regop.sv
module ipc_regop
    import ipc_pkg::*;
#(
    parameter logic [SRC_W-1:0] REQ_NUM = 24'd2
) (
    input  ipc_state_t         cur,
    input  logic [OP_W-1:0]    op_code,
    input  logic [WORD_W-1:0]  wdata,
    output ipc_state_t         nxt,
    output ipc_note_t          rej,
    output ipc_note_t          eoi,
    output logic               resend
);
    localparam int PRI_LO = SRC_W;

    ipc_op_e          op;
    logic [PRI_W-1:0] wr_pri;
    ipc_step_t        chk;

    assign op     = ipc_op_e'(op_code);
    assign wr_pri = wdata[PRI_W-1:0];

    always_comb begin
        nxt    = cur;
        rej    = '0;
        eoi    = '0;
        resend = 1'b0;
        chk    = '0;
        unique case (op)
            OP_ACCEPT: begin
                nxt.cur_pri  = cur.pend_pri;
                nxt.src      = '0;
                nxt.pend_pri = PRI_NONE;
                nxt.owned    = 1'b0;
            end
            OP_SET_PRI: begin
                nxt.cur_pri = wr_pri;
                if (wr_pri < cur.cur_pri) begin
                    if (slot_busy(cur) && wr_pri <= cur.pend_pri) begin
                        nxt.src      = '0;
                        nxt.pend_pri = PRI_NONE;
                        nxt.owned    = 1'b0;
                        if (cur.owned) begin
                            rej.valid = 1'b1;
                            rej.src   = cur.src;
                        end
                    end
                end else if (!slot_busy(cur)) begin
                    resend = 1'b1;
                    if (cur.req_pri < wr_pri) begin
                        chk = req_try(nxt, REQ_NUM);
                        nxt = chk.st;
                        rej = chk.rej;
                    end
                end
            end
            OP_EOI: begin
                nxt.cur_pri = wdata[WORD_W-1:PRI_LO];
                eoi.valid   = 1'b1;
                eoi.src     = wdata[SRC_W-1:0];
                if (!slot_busy(cur)) begin
                    resend = 1'b1;
                    if (cur.req_pri < nxt.cur_pri) begin
                        chk = req_try(nxt, REQ_NUM);
                        nxt = chk.st;
                        rej = chk.rej;
                    end
                end
            end
            OP_SET_REQ: begin
                nxt.req_pri = wr_pri;
                if (wr_pri < cur.cur_pri) begin
                    chk = req_try(nxt, REQ_NUM);
                    nxt = chk.st;
                    rej = chk.rej;
                end
            end
            default: begin
                nxt = cur;
            end
        endcase
    end

endmodule

// File: rtl/ipc_offer.sv
module ipc_offer
    import ipc_pkg::*;
(
    input  ipc_state_t        cur,
    input  logic              ofr_valid,
    input  logic [SRC_W-1:0]  ofr_src,
    input  logic [PRI_W-1:0]  ofr_pri,
    output ipc_state_t        nxt,
    output logic              refuse,
    output ipc_note_t         rej
);
    logic beats_cpu;
    logic beats_slot;
    logic win;

    assign beats_cpu  = ofr_pri < cur.cur_pri;
    assign beats_slot = !slot_busy(cur) || (ofr_pri < cur.pend_pri);
    assign win        = ofr_valid && (ofr_src != '0) && beats_cpu && beats_slot;
    assign refuse     = ofr_valid && !win;

    always_comb begin
        nxt = cur;
        rej = '0;
        if (win) begin
            if (slot_busy(cur) && cur.owned) begin
                rej.valid = 1'b1;
                rej.src   = cur.src;
            end
            nxt.src      = ofr_src;
            nxt.pend_pri = ofr_pri;
            nxt.owned    = 1'b1;
        end
    end

endmodule

// File: rtl/ipc_core.sv
module ipc_core
    import ipc_pkg::*;
#(
    parameter logic [SRC_W-1:0] REQ_NUM = 24'd2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_code,
    input  logic [WORD_W-1:0] op_wdata,
    output logic [WORD_W-1:0] rd_word,
    output logic [PRI_W-1:0]  rd_req_pri,
    input  logic              ofr_valid,
    input  logic [SRC_W-1:0]  ofr_src,
    input  logic [PRI_W-1:0]  ofr_pri,
    output logic              ofr_reject,
    output logic              irq_out,
    output logic              rej_valid,
    output logic [SRC_W-1:0]  rej_src,
    output logic              eoi_valid,
    output logic [SRC_W-1:0]  eoi_src,
    output logic              resend_req
);
    ipc_state_t st_q;
    ipc_state_t st_a;
    ipc_state_t st_b;
    ipc_note_t  rej_a;
    ipc_note_t  rej_b;
    ipc_note_t  rej_sel;
    ipc_note_t  eoi_a;
    logic       resend_a;

    // Stage A: register operation
    ipc_regop #(.REQ_NUM(REQ_NUM)) u_regop (
        .cur     (st_q),
        .op_code (op_code),
        .wdata   (op_wdata),
        .nxt     (st_a),
        .rej     (rej_a),
        .eoi     (eoi_a),
        .resend  (resend_a)
    );

    // Stage B: offer judged against the post-operation state
    ipc_offer u_offer (
        .cur       (st_a),
        .ofr_valid (ofr_valid),
        .ofr_src   (ofr_src),
        .ofr_pri   (ofr_pri),
        .nxt       (st_b),
        .refuse    (ofr_reject),
        .rej       (rej_b)
    );

    // Stage A clears ownership when it rejects, so at most one reject per cycle
    assign rej_sel = rej_a.valid ? rej_a : rej_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cur_pri  <= '0;
            st_q.src      <= '0;
            st_q.pend_pri <= PRI_NONE;
            st_q.owned    <= 1'b0;
            st_q.req_pri  <= PRI_NONE;
            irq_out       <= 1'b0;
            rej_valid     <= 1'b0;
            rej_src       <= '0;
            eoi_valid     <= 1'b0;
            eoi_src       <= '0;
            resend_req    <= 1'b0;
        end else begin
            st_q       <= st_b;
            irq_out    <= slot_busy(st_b);
            rej_valid  <= rej_sel.valid;
            rej_src    <= rej_sel.src;
            eoi_valid  <= eoi_a.valid;
            eoi_src    <= eoi_a.src;
            resend_req <= resend_a;
        end
    end

    assign rd_word    = {st_q.cur_pri, st_q.src};
    assign rd_req_pri = st_q.req_pri;

endmodule

// File: rtl/ipc_checker.sv
module ipc_checker
    import ipc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_code,
    input logic [WORD_W-1:0] op_wdata,
    input logic [WORD_W-1:0] rd_word,
    input logic [PRI_W-1:0]  rd_req_pri,
    input logic              ofr_valid,
    input logic              ofr_reject,
    input logic              irq_out,
    input logic              eoi_valid,
    input logic [SRC_W-1:0]  eoi_src
);
    a_r2_line_tracks_slot: assert property (@(posedge clk) disable iff (rst)
        irq_out == (rd_word[SRC_W-1:0] != '0));

    a_r3_refusal_keeps_word: assert property (@(posedge clk) disable iff (rst)
        (ofr_valid && ofr_reject && op_code == OP_IDLE) |=> $stable(rd_word));

    a_r4_winner_raises_line: assert property (@(posedge clk) disable iff (rst)
        (ofr_valid && !ofr_reject) |=> irq_out);

    a_r5_request_stored: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_SET_REQ) |=> (rd_req_pri == $past(op_wdata[PRI_W-1:0])));

    a_r6_accept_drops_line: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_ACCEPT && !ofr_valid) |=> !irq_out);

    a_r7_poll_no_change: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_POLL && !ofr_valid) |=> ($stable(rd_word) && $stable(rd_req_pri)));

    a_r10_eoi_forwarded: assert property (@(posedge clk) disable iff (rst)
        (op_code == OP_EOI) |=> (eoi_valid && eoi_src == $past(op_wdata[SRC_W-1:0])));

    a_r12_eoi_single: assert property (@(posedge clk) disable iff (rst)
        (op_code != OP_EOI) |=> !eoi_valid);

endmodule

bind ipc_core ipc_checker u_ipc_checker (
    .clk        (clk),
    .rst        (rst),
    .op_code    (op_code),
    .op_wdata   (op_wdata),
    .rd_word    (rd_word),
    .rd_req_pri (rd_req_pri),
    .ofr_valid  (ofr_valid),
    .ofr_reject (ofr_reject),
    .irq_out    (irq_out),
    .eoi_valid  (eoi_valid),
    .eoi_src    (eoi_src)
);

// File: tb/ipc_core_bench.sv
module ipc_core_bench;
    localparam int CLK_P = 10;
    localparam int N_RAND = 3000;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  op_code;
    logic [31:0] op_wdata;
    logic [31:0] rd_word;
    logic [7:0]  rd_req_pri;
    logic        ofr_valid;
    logic [23:0] ofr_src;
    logic [7:0]  ofr_pri;
    logic        ofr_reject;
    logic        irq_out;
    logic        rej_valid;
    logic [23:0] rej_src;
    logic        eoi_valid;
    logic [23:0] eoi_src;
    logic        resend_req;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model of the presenter
    logic [7:0]  m_cur, m_pp, m_req;
    logic [23:0] m_src;
    logic        m_own;
    logic        e_rej_v, e_eoi_v, e_res;
    logic [23:0] e_rej_s, e_eoi_s;

    always #(CLK_P/2) clk = ~clk;

    ipc_core u_ipc_core (
        .clk(clk), .rst(rst), .op_code(op_code), .op_wdata(op_wdata),
        .rd_word(rd_word), .rd_req_pri(rd_req_pri), .ofr_valid(ofr_valid),
        .ofr_src(ofr_src), .ofr_pri(ofr_pri), .ofr_reject(ofr_reject),
        .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_req(resend_req)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic m_reject_slot();
        e_rej_v = 1'b1;
        e_rej_s = m_src;
    endtask

    // inter-processor request check
    task automatic m_req_load();
        if (m_src != 0 && m_pp <= m_req) return;
        if (m_src != 0 && m_own) m_reject_slot();
        m_src = 24'd2;
        m_pp  = m_req;
        m_own = 1'b0;
    endtask

    task automatic m_reset();
        m_cur = 8'h00; m_src = 0; m_pp = 8'hFF; m_own = 0; m_req = 8'hFF;
    endtask

    // compute expectations for one cycle of stimulus; returns expected refusal
    task automatic m_step(input logic [2:0] op, input logic [31:0] wd, input logic ov,
                          input logic [23:0] os, input logic [7:0] opr, output logic refuse);
        logic [7:0] v;
        e_rej_v = 0; e_rej_s = 0; e_eoi_v = 0; e_eoi_s = 0; e_res = 0;
        v = wd[7:0];
        case (op)
            3'd1: begin m_cur = m_pp; m_src = 0; m_pp = 8'hFF; m_own = 0; end
            3'd3: begin
                if (v < m_cur) begin
                    m_cur = v;
                    if (m_src != 0 && v <= m_pp) begin
                        if (m_own) m_reject_slot();
                        m_src = 0; m_pp = 8'hFF; m_own = 0;
                    end
                end else begin
                    m_cur = v;
                    if (m_src == 0) begin
                        e_res = 1;
                        if (m_req < m_cur) m_req_load();
                    end
                end
            end
            3'd4: begin
                m_cur = wd[31:24];
                e_eoi_v = 1; e_eoi_s = wd[23:0];
                if (m_src == 0) begin
                    e_res = 1;
                    if (m_req < m_cur) m_req_load();
                end
            end
            3'd5: begin
                m_req = v;
                if (m_req < m_cur) m_req_load();
            end
            default: ;
        endcase
        refuse = 0;
        if (ov) begin
            if (os == 0 || opr >= m_cur || (m_src != 0 && m_pp <= opr)) refuse = 1;
            else begin
                if (m_src != 0 && m_own) m_reject_slot();
                m_src = os; m_pp = opr; m_own = 1;
            end
        end
    endtask

    // one stimulus cycle: called at a falling edge, returns at the next one
    task automatic cycle(input logic [2:0] op, input logic [31:0] wd, input logic ov,
                         input logic [23:0] os, input logic [7:0] opr, input string tag);
        logic exp_ref;
        logic [31:0] word_before;
        op_code = op; op_wdata = wd; ofr_valid = ov; ofr_src = os; ofr_pri = opr;
        word_before = {m_cur, m_src};
        #1;
        if (op == 3'd1)
            check(rd_word == word_before, {tag, " R6 accept returns word"}, rd_word, word_before);
        m_step(op, wd, ov, os, opr, exp_ref);
        if (ov)
            check(ofr_reject == exp_ref, {tag, " R3 same-cycle refusal"},
                  32'(ofr_reject), 32'(exp_ref));
        @(negedge clk);
        check(rd_word == {m_cur, m_src}, {tag, " R2 pending word"}, rd_word, {m_cur, m_src});
        check(rd_req_pri == m_req, {tag, " R7 request priority"}, 32'(rd_req_pri), 32'(m_req));
        check(irq_out == (m_src != 0), {tag, " R2 irq line"}, 32'(irq_out), 32'(m_src != 0));
        check(rej_valid == e_rej_v && (!e_rej_v || rej_src == e_rej_s),
              {tag, " R4 reject pulse"}, {7'd0, rej_valid, rej_src}, {7'd0, e_rej_v, e_rej_s});
        check(eoi_valid == e_eoi_v && (!e_eoi_v || eoi_src == e_eoi_s),
              {tag, " R10 eoi pulse"}, {7'd0, eoi_valid, eoi_src}, {7'd0, e_eoi_v, e_eoi_s});
        check(resend_req == e_res, {tag, " R9 resend pulse"}, 32'(resend_req), 32'(e_res));
    endtask

    function automatic logic [7:0] pick_pri();
        int r;
        r = int'($urandom % 10);
        return (r == 9) ? 8'hFF : 8'(r);
    endfunction

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog R12 actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; op_code = 0; op_wdata = 0; ofr_valid = 0; ofr_src = 0; ofr_pri = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        check(rd_word == 0, "R1 word", rd_word, 0);
        check(rd_req_pri == 8'hFF, "R1 request", 32'(rd_req_pri), 32'hFF);
        check(!irq_out && !rej_valid && !eoi_valid && !resend_req, "R1 outputs",
              {28'd0, irq_out, rej_valid, eoi_valid, resend_req}, 0);
        // directed corners
        cycle(3'd3, 32'h10, 0, 0, 0, "R9 lower priority idle");
        cycle(3'd0, 0, 1, 24'd7, 8'd8, "R4 first offer");
        cycle(3'd0, 0, 1, 24'd9, 8'd8, "R3 equal priority refused");
        cycle(3'd0, 0, 1, 24'd9, 8'd3, "R4 displace");
        cycle(3'd5, 32'h3, 0, 0, 0, "R5 request ties pending");
        cycle(3'd2, 0, 0, 0, 0, "R7 poll");
        cycle(3'd5, 32'h1, 0, 0, 0, "R5 request wins");
        cycle(3'd1, 0, 0, 0, 0, "R6 accept");
        cycle(3'd4, 32'h10_000002, 0, 0, 0, "R10 eoi");
        cycle(3'd3, 32'h0, 0, 0, 0, "R8 raise removes request");
        cycle(3'd3, 32'h20, 1, 24'd5, 8'd0, "R11 op then offer");
        cycle(3'd0, 0, 1, 24'd0, 8'd0, "R3 source zero");
        cycle(3'd0, 0, 1, 24'd6, 8'h30, "R3 worse than cpu");
        cycle(3'd3, 32'h0, 0, 0, 0, "R8 raise rejects owner");
        cycle(3'd1, 0, 0, 0, 0, "R6 accept empty");
        // random traffic
        for (int i = 0; i < N_RAND; i++) begin
            logic [2:0]  op;
            logic [31:0] wd;
            logic        ov;
            logic [23:0] os;
            op = 3'($urandom % 6);
            wd = (op == 3'd4) ? {pick_pri(), 24'($urandom % 16)} : {24'd0, pick_pri()};
            ov = 1'($urandom % 2);
            os = 24'($urandom % 16);
            cycle(op, wd, ov, os, pick_pri(), "R12 random");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule